// File: doc/BRIEF.md
# Pulse-Position Clock Encoder

The encoder turns a stream of data bits into a square-wave clock. Each bit period holds exactly one high pulse. The data bit does not change the pulse width. It only picks one of two start positions: a reference position, or one delayed by a quarter of the period. Because every pulse lasts half a period, the duty cycle is always 50%. The average level of the line therefore stays the same for any run of ones or zeros, and a receiver can take its power and its timing from the same signal.

The block runs on an oversampling clock with `TICKS_PER_BIT` clocks per bit period, 8 by default, and drives a one-bit registered output on that clock. Data enters through a valid/ready handshake. The encoder takes a new bit only in the part of the period where both candidate waveforms are low, so changing the select cannot cause a glitch. If no bit is offered at that moment, it sends a zero so that the clock keeps running. A low `en` stops the waveform and restarts the period count.

Top module: `ppm_clock_encoder`

## Requirements
- R1: While `rst_n` is low, `ppm_out` and `in_ready` are 0.
- R2: While `en` is high, the bit period is `TICKS_PER_BIT` clocks and holds exactly one high pulse of `TICKS_PER_BIT/2` clocks.
- R3: Ticks are numbered 0 to 7 within a period. Tick t is shown on `ppm_out` in the clock cycle after the internal counter holds t. The first cycle after `en` is first sampled high shows tick 0. Data 0 gives high on ticks 0-3. Data 1 gives high on ticks 2-5.
- R4: `in_ready` is high for exactly one clock per period, while the counter holds tick 6, and only when `en` is high. A bit is accepted when `in_valid` and `in_ready` are both high. It is sent in the following period.
- R5: If `in_valid` is low while `in_ready` is high, the following period carries data 0.
- R6: Ticks 6 and 7 are low for both data values. The select changes only at the boundary into tick 7.
- R7: While `en` is low, `ppm_out` is 0 from the next clock and the counter returns to tick 0. The held bit is cleared, so the first period after re-enabling carries data 0.
- R8: Every full period holds exactly `TICKS_PER_BIT/2` high clocks, whatever the data pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, `TICKS_PER_BIT` cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the encoder; low holds the line low and restarts the count |
| in_valid | input | 1 | A data bit is offered |
| in_ready | output | 1 | Single-cycle pulse: the encoder takes a bit in this cycle |
| in_data | input | 1 | Data bit to embed |
| ppm_out | output | 1 | Registered pulse-position modulated clock |

## Verification
The checker tests four things on every cycle:
- every falling edge ends a pulse of exactly half a period;
- `in_ready` never lasts more than one clock and never appears without `en`;
- the cycle after a handshake is low;
- a low `en` forces the line low on the next clock.

Some behaviours only the bench's scenarios can show. These are the exact tick positions of each data value, the period-by-period order of accepted bits, the zero inserted when no bit is offered, and the cleared bit after re-enabling. The bench shows them by decoding every period against a queue of expected bits.

// File: rtl/ppm_clock_encoder.sv
module ppm_clock_encoder #(
  parameter int TICKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_data,
  output logic ppm_out
);
  localparam int CW   = $clog2(TICKS_PER_BIT);
  localparam int QTR  = TICKS_PER_BIT / 4;
  localparam int HALF = TICKS_PER_BIT / 2;
  localparam logic [CW-1:0] T_HALF  = CW'(HALF);
  localparam logic [CW-1:0] T_QTR   = CW'(QTR);
  localparam logic [CW-1:0] T_LATCH = CW'(QTR + HALF);
  localparam logic [CW-1:0] T_LAST  = CW'(TICKS_PER_BIT - 1);

  generate
    if (TICKS_PER_BIT < 4 || TICKS_PER_BIT % 4 != 0) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be a multiple of 4, at least 4");
    end
  endgenerate

  logic [CW-1:0] tick;
  logic          sel;
  logic          lvl_ref, lvl_dly, lvl;

  // reference phase high in the first half; delayed phase starts a quarter later
  assign lvl_ref  = tick < T_HALF;
  assign lvl_dly  = (tick >= T_QTR) && (tick < T_LATCH);
  assign lvl      = sel ? lvl_dly : lvl_ref;
  // both phases are low from T_LATCH to the end of the period
  assign in_ready = en && (tick == T_LATCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick    <= '0;
      sel     <= 1'b0;
      ppm_out <= 1'b0;
    end else if (!en) begin
      tick    <= '0;
      sel     <= 1'b0;
      ppm_out <= 1'b0;
    end else begin
      tick    <= (tick == T_LAST) ? '0 : tick + 1'b1;
      ppm_out <= lvl;
      if (in_ready) sel <= in_valid & in_data;
    end
  end
endmodule

// File: rtl/ppm_clock_encoder_chk.sv
module ppm_clock_encoder_chk #(
  parameter int TICKS_PER_BIT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic in_valid,
  input logic in_ready,
  input logic in_data,
  input logic ppm_out
);
  localparam int LW = $clog2(TICKS_PER_BIT) + 1;
  localparam logic [LW-1:0] HALF_LEN = LW'(TICKS_PER_BIT / 2);

  logic [LW-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_len <= '0;
    else if (ppm_out) hi_len <= hi_len + 1'b1;
    else hi_len <= '0;
  end

  // R2, R8: every pulse ended by the encoder lasts half a period
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ppm_out) && $past(en) |-> hi_len == HALF_LEN);

  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  a_r4_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> en);

  a_r6_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !ppm_out);

  a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ppm_out);
endmodule

bind ppm_clock_encoder ppm_clock_encoder_chk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .ppm_out(ppm_out)
);

// File: tb/test_ppm_clock_encoder.sv
`timescale 1ns/1ps
module test_ppm_clock_encoder;
  logic clk = 1'b0;
  logic rst_n, en, in_valid, in_data;
  logic in_ready, ppm_out;

  int n_chk = 0;
  int n_err = 0;
  bit exp_q[$];
  logic [7:0] pat;
  int ph = 0;
  logic en_d = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ppm_clock_encoder i_ppm_clock_encoder (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .ppm_out(ppm_out)
  );

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endfunction

  // expected model: first period after enabling carries 0 (R7)
  always @(posedge clk) begin
    if (!rst_n || !en) exp_q.delete();
    else if (!en_d) exp_q.push_back(1'b0);
    en_d <= rst_n && en;
  end

  // monitor: decode each full period and compare with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (en_d) begin
        chk(in_ready == (en && ((ph + 1) % 8 == 6)), "R4", "in_ready", in_ready,
            en && ((ph + 1) % 8 == 6));
        pat[ph] = ppm_out;
        ph++;
        if (en && in_ready) exp_q.push_back(in_valid ? in_data : 1'b0); // R4, R5
        if (ph == 8) begin
          ph = 0;
          if (exp_q.size() == 0) chk(1'b0, "R3", "missing expected bit", 0, 1);
          else begin
            automatic bit b = exp_q.pop_front();
            automatic logic [7:0] e = b ? 8'h3C : 8'h0F;
            chk(pat == e, "R3", "period pattern", pat, e);
            chk($countones(pat) == 4, "R8", "high count", $countones(pat), 4);
            chk(pat[7:6] == 2'b00, "R6", "ticks 6-7", pat[7:6], 0);
          end
        end
      end else begin
        ph = 0;
        chk(ppm_out == 1'b0, "R7", "ppm_out while disabled", ppm_out, 0);
        chk(in_ready == 1'b0, "R4", "in_ready at restart", in_ready, 0);
      end
    end
  end

  task automatic send(input bit b);
    in_valid = 1'b1;
    in_data  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
    in_data  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst_n = 1'b0; en = 1'b0; in_valid = 1'b0; in_data = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ppm_out == 1'b0, "R1", "ppm_out in reset", ppm_out, 0);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    idle(2);
    en = 1'b1;
    idle(24);                                   // R5: idle periods send 0
    send(1'b1); send(1'b0); send(1'b1); send(1'b0);
    repeat (5) send(1'b1);                      // R8: run of ones
    repeat (3) send(1'b0);
    for (int i = 0; i < 16; i++) begin
      send(lfsr[0]);
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    send(1'b1);
    idle(10);                                   // R5: one missed slot
    send(1'b1);
    send(1'b1);
    idle(3);
    en = 1'b0;                                  // R7: stop mid-period
    idle(6);
    en = 1'b1;
    idle(16);
    send(1'b1);
    idle(20);
    done = 1'b1;
    summary();
  end
endmodule